// File: doc/BRIEF.md
# Macroblock Byte Output Interface

This block moves one stored macroblock out of a shared frame memory and hands it to a downstream encoder as a stream of bytes. A transfer begins when the encoder raises its request line. The block then fetches 16-bit words through a memory port that it shares with a line writer. The writer owns most cycles, so this block may only read in one fixed slot out of every eight. Words are collected four at a time in a ping-pong buffer. While one bank fills, the other bank is serialised onto an 8-bit data bus. A one-cycle strobe marks each byte, and strobes come at most once every four clocks.

Each transfer is one macroblock of 384 bytes, which is 192 consecutive word addresses. The read address counter runs on across transfers. After the last byte the block raises a one-cycle done pulse. It then waits until the request line has fallen and risen again before it sends anything more. The block also passes a frame-ready flag to its output, masked by a host enable bit.

Top module: `mb_out_xfer`

## Requirements
- R1: `mem_rd_o` is asserted only in cycles where the number of rising clock edges since reset was released, taken modulo 8, equals 7. At most one read is issued per 8 cycles.
- R2: Each transfer issues exactly 192 reads. Their addresses are consecutive and start at 0 after reset. Each transfer continues from where the previous one ended.
- R3: `stb_o` is a one-cycle pulse. It is high only in cycles where the edge count since reset release is a multiple of 4, so strobes are at least 4 cycles apart.
- R4: Bytes leave in read-address order. From each word, bits [7:0] are sent before bits [15:8]. `byte_o` carries the byte in the cycle where `stb_o` is high.
- R5: Each transfer produces exactly 384 strobes. `done_o` is high for exactly the one cycle that follows the 384th strobe.
- R6: The first strobe of a transfer appears no more than 60 cycles after the request pin rises.
- R7: The 384th strobe appears no more than 1870 cycles after the request pin rises.
- R8: When a transfer completes while the request is still high, no read and no strobe occurs until the request has gone low and then high again.
- R9: If the request falls partway through a transfer, that transfer still completes in full.
- R10: `frame_rdy_o` equals `frame_flag_i AND frame_en_i` as sampled at the previous clock edge. It is therefore low whenever the enable bit was clear.
- R11: After reset, `stb_o`, `done_o`, `mem_rd_o`, `frame_rdy_o` and `byte_o` are all 0.
- R12: A rising edge of the request during a running transfer is ignored. It neither restarts nor queues a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Asynchronous request from the encoder |
| frame_flag_i | input | 1 | Frame-stored flag from the memory writer |
| frame_en_i | input | 1 | Host enable bit that gates the frame-ready output |
| frame_rdy_o | output | 1 | Gated, registered frame-ready flag |
| mem_rd_o | output | 1 | Read request in the granted memory slot |
| mem_addr_o | output | 18 | Word address of the read |
| mem_rdata_i | input | 16 | Read data, valid in the cycle after `mem_rd_o` |
| byte_o | output | 8 | Output byte |
| stb_o | output | 1 | Byte qualifying strobe |
| done_o | output | 1 | One-cycle pulse after the last byte of a macroblock |

## Verification
The hardest case to reach from the pins is a request edge that arrives while a transfer is already in flight. Because of the two-stage synchroniser, the edge must be a clean fall and rise that both land inside the roughly 1600-cycle busy window. To create it, the bench drops the request 200 cycles into the second transfer and raises it again 100 cycles later. It then holds the line high for several hundred cycles after done and checks that no extra reads or strobes appear. A reference model built from queues predicts every byte, every read address, and the done and frame-ready levels on each clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [0:0] {
      XF_IDLE = 1'b0,
      XF_RUN  = 1'b1
   } xfer_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/mbx_req_sync.sv
module mbx_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_async_i,
   output logic rise_o
);
   logic [STAGES-1:0] shift_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbx_req_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         last_q  <= 1'b0;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], req_async_i};
         last_q  <= shift_q[STAGES-1];
      end
   end

   assign rise_o = shift_q[STAGES-1] & ~last_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R8
endmodule

// File: rtl/mbx_slot_timer.sv
module mbx_slot_timer #(
   parameter int WINDOW     = 32,
   parameter int SLOTS      = 4,
   parameter int STROBE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_hit_o,
   output logic tick_o
);
   localparam int PERIOD = WINDOW / SLOTS;
   localparam int WIN_W  = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam int DIV_W  = $clog2(STROBE_DIV);

   logic [WIN_W-1:0] win_q;
   logic [DIV_W-1:0] div_q;

   generate
      if (WINDOW % SLOTS != 0) begin : g_bad_window
         $error("mbx_slot_timer: WINDOW must be a multiple of SLOTS");
      end
      if (PERIOD < 2) begin : g_bad_period
         $error("mbx_slot_timer: slot period must be at least 2");
      end
      if (STROBE_DIV < 2) begin : g_bad_div
         $error("mbx_slot_timer: STROBE_DIV must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= '0;
         div_q <= '0;
      end else begin
         win_q <= (win_q == WIN_W'(WINDOW - 1)) ? '0 : win_q + 1'b1;
         div_q <= (div_q == DIV_W'(STROBE_DIV - 1)) ? '0 : div_q + 1'b1;
      end
   end

   generate
      if (mbx_pkg::is_pow2(PERIOD)) begin : g_slot_mask
         localparam int PB = $clog2(PERIOD);
         assign slot_hit_o = &win_q[PB-1:0];
      end else begin : g_slot_mod
         assign slot_hit_o = ((int'(win_q) % PERIOD) == PERIOD - 1);
      end
   endgenerate

   assign tick_o = (div_q == DIV_W'(STROBE_DIV - 1));

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R3
endmodule

// File: rtl/mbx_word_buf.sv
module mbx_word_buf #(
   parameter int WORD_W    = 16,
   parameter int BURST     = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              tick_i,
   output logic              room_o,
   output logic              stb_o,
   output logic [7:0]        byte_o
);
   localparam int BPW    = WORD_W / 8;
   localparam int NBYTES = BURST * BPW;
   localparam int WI_W   = $clog2(BURST);
   localparam int BI_W   = $clog2(NBYTES);
   localparam int LB_W   = $clog2(BPW);

   generate
      if (WORD_W % 8 != 0 || !mbx_pkg::is_pow2(BPW) || BPW < 2) begin : g_bad_word
         $error("mbx_word_buf: WORD_W must be a power-of-two number of bytes, at least 2");
      end
      if (!mbx_pkg::is_pow2(BURST) || BURST < 2) begin : g_bad_burst
         $error("mbx_word_buf: BURST must be a power of two, at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] store_q [2][BURST];
   logic [1:0]        full_q, full_nx;
   logic              wr_bank_q, rd_bank_q;
   logic [WI_W-1:0]   wr_idx_q;
   logic [BI_W-1:0]   byte_idx_q;
   logic              send_fire;
   logic [WORD_W-1:0] word_sel;
   logic [LB_W-1:0]   lane_raw, lane;

   assign room_o    = !full_q[wr_bank_q];
   assign send_fire = tick_i & full_q[rd_bank_q];
   assign word_sel  = store_q[rd_bank_q][byte_idx_q[BI_W-1:LB_W]];
   assign lane_raw  = byte_idx_q[LB_W-1:0];

   generate
      if (LOW_FIRST) begin : g_low_first
         assign lane = lane_raw;
      end else begin : g_high_first
         assign lane = LB_W'(BPW - 1) - lane_raw;
      end
   endgenerate

   always_comb begin
      full_nx = full_q;
      if (wr_en_i && wr_idx_q == WI_W'(BURST - 1)) full_nx[wr_bank_q] = 1'b1;
      if (send_fire && byte_idx_q == BI_W'(NBYTES - 1)) full_nx[rd_bank_q] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) store_q[wr_bank_q][wr_idx_q] <= wr_data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q     <= '0;
         wr_bank_q  <= 1'b0;
         rd_bank_q  <= 1'b0;
         wr_idx_q   <= '0;
         byte_idx_q <= '0;
         stb_o      <= 1'b0;
         byte_o     <= '0;
      end else begin
         full_q <= full_nx;
         stb_o  <= send_fire;
         if (wr_en_i) begin
            wr_idx_q <= wr_idx_q + 1'b1;
            if (wr_idx_q == WI_W'(BURST - 1)) wr_bank_q <= ~wr_bank_q;
         end
         if (send_fire) begin
            byte_o     <= word_sel[lane*8 +: 8];
            byte_idx_q <= byte_idx_q + 1'b1;
            if (byte_idx_q == BI_W'(NBYTES - 1)) rd_bank_q <= ~rd_bank_q;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> !full_q[wr_bank_q]); // R2
   AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_o && !$past(send_fire) |-> $stable(byte_o)); // R4
endmodule

// File: rtl/mb_out_xfer.sv
module mb_out_xfer #(
   parameter int WORD_W      = 16,
   parameter int MB_BYTES    = 384,
   parameter int WINDOW      = 32,
   parameter int SLOTS       = 4,
   parameter int BURST       = 4,
   parameter int STROBE_DIV  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 18,
   parameter bit LOW_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              frame_flag_i,
   input  logic              frame_en_i,
   output logic              frame_rdy_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic [7:0]        byte_o,
   output logic              stb_o,
   output logic              done_o
);
   import mbx_pkg::*;

   localparam int BPW      = WORD_W / 8;
   localparam int MB_WORDS = MB_BYTES / BPW;
   localparam int IW       = $clog2(MB_WORDS + 1);
   localparam int SW       = $clog2(MB_BYTES);

   generate
      if (MB_BYTES % (BPW * BURST) != 0) begin : g_bad_mb
         $error("mb_out_xfer: MB_BYTES must fill a whole number of buffer banks");
      end
   endgenerate

   xfer_state_e       state_q;
   logic [IW-1:0]     issued_q;
   logic [SW-1:0]     sent_q;
   logic              rd_q;
   logic              rise, slot_hit, tick, room;

   mbx_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .req_async_i(req_i), .rise_o(rise));

   mbx_slot_timer #(.WINDOW(WINDOW), .SLOTS(SLOTS), .STROBE_DIV(STROBE_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .slot_hit_o(slot_hit), .tick_o(tick));

   mbx_word_buf #(.WORD_W(WORD_W), .BURST(BURST), .LOW_FIRST(LOW_FIRST)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en_i(rd_q), .wr_data_i(mem_rdata_i),
      .tick_i(tick), .room_o(room), .stb_o(stb_o), .byte_o(byte_o));

   assign mem_rd_o = (state_q == XF_RUN) && (issued_q < IW'(MB_WORDS)) && room && slot_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= XF_IDLE;
         issued_q    <= '0;
         sent_q      <= '0;
         rd_q        <= 1'b0;
         mem_addr_o  <= '0;
         done_o      <= 1'b0;
         frame_rdy_o <= 1'b0;
      end else begin
         frame_rdy_o <= frame_flag_i & frame_en_i;
         rd_q        <= mem_rd_o;
         done_o      <= 1'b0;
         if (mem_rd_o) begin
            mem_addr_o <= mem_addr_o + 1'b1;
            issued_q   <= issued_q + 1'b1;
         end
         if (state_q == XF_IDLE) begin
            if (rise) begin
               state_q  <= XF_RUN;
               issued_q <= '0;
               sent_q   <= '0;
            end
         end else if (stb_o) begin
            if (sent_q == SW'(MB_BYTES - 1)) begin
               sent_q  <= '0;
               done_o  <= 1'b1;
               state_q <= XF_IDLE;
            end else begin
               sent_q <= sent_q + 1'b1;
            end
         end
      end
   end

   AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |=> !mem_rd_o); // R1
   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5
   AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(stb_o)); // R5
   AST_FRDY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_en_i) |-> !frame_rdy_o); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !stb_o); // R8
endmodule

// File: tb/test_mb_out_xfer.sv
module test_mb_out_xfer;
   localparam int MBB = 384;
   localparam int MBW = 192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        frame_flag_i = 1'b0;
   logic        frame_en_i = 1'b0;
   logic        frame_rdy_o, mem_rd_o, stb_o, done_o;
   logic [17:0] mem_addr_o;
   logic [15:0] mem_rdata_i = '0;
   logic [7:0]  byte_o;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;

   mb_out_xfer i_mb_out_xfer (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .frame_flag_i(frame_flag_i),
      .frame_en_i(frame_en_i), .frame_rdy_o(frame_rdy_o), .mem_rd_o(mem_rd_o),
      .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .byte_o(byte_o),
      .stb_o(stb_o), .done_o(done_o));

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (rst_n) cyc <= cyc + 1;
      else       cyc <= 0;
   end

   function automatic logic [15:0] word_of(input int a);
      return {8'((a * 3 + 1) & 255), 8'((a ^ 'hC3) & 255)};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // reference model state
   logic [7:0] exp_q[$];
   int  base_addr = 0;
   int  exp_addr = 0;
   int  rise_cyc = 0;
   int  nstb = 0;
   int  nrd = 0;
   int  last_stb_cyc = -10;
   int  ndone = 0;
   bit  open_xfer = 0;
   bit  pend = 0;
   int  pend_addr = 0;
   logic prev_flag = 0, prev_en = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         // read data one cycle after the read
         if (pend) mem_rdata_i <= word_of(pend_addr);
         pend = 0;
         // R10: gated frame-ready
         check(frame_rdy_o == (prev_flag & prev_en), "R10 frame_rdy", frame_rdy_o, prev_flag & prev_en);
         prev_flag = frame_flag_i;
         prev_en   = frame_en_i;
         // reads
         if (mem_rd_o) begin
            check(open_xfer, "R8/R12 read outside transfer", 1, 0);
            check(cyc % 8 == 7, "R1 read slot phase", cyc % 8, 7);
            check(int'(mem_addr_o) == exp_addr, "R2 read address", mem_addr_o, exp_addr);
            pend = 1;
            pend_addr = int'(mem_addr_o);
            exp_addr++;
            nrd++;
         end
         // strobes
         if (stb_o) begin
            check(cyc % 4 == 0, "R3 strobe phase", cyc % 4, 0);
            if (exp_q.size() == 0) begin
               check(0, "R8/R12 unexpected strobe", byte_o, -1);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(byte_o == e, "R4 byte value", byte_o, e);
               nstb++;
               if (nstb == 1)
                  check(cyc - rise_cyc <= 60, "R6 first strobe latency", cyc - rise_cyc, 60);
               if (nstb == MBB) begin
                  check(cyc - rise_cyc <= 1870, "R7 transfer time", cyc - rise_cyc, 1870);
                  last_stb_cyc = cyc;
               end
            end
         end
         // R5: done exactly one cycle after the last strobe
         begin
            bit exp_done;
            exp_done = open_xfer && (nstb == MBB) && (last_stb_cyc == cyc - 1);
            check(done_o == exp_done, "R5 done pulse", done_o, exp_done);
            if (exp_done) begin
               check(nrd == MBW, "R2 reads per macroblock", nrd, MBW);
               check(nstb == MBB, "R5 strobes per macroblock", nstb, MBB);
               open_xfer = 0;
               nstb = 0;
               nrd = 0;
               ndone++;
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic start_xfer();
      for (int w = 0; w < MBW; w++) begin
         logic [15:0] d;
         d = word_of(base_addr + w);
         exp_q.push_back(d[7:0]);
         exp_q.push_back(d[15:8]);
      end
      base_addr += MBW;
      open_xfer = 1;
      rise_cyc = cyc;
      req_i = 1'b1;
   endtask

   task automatic wait_done(input int target);
      while (ndone < target) tick(1);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      while (1) begin
         @(posedge clk);
         if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
         end
      end
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check(stb_o == 0, "R11 stb after reset", stb_o, 0);
      check(done_o == 0, "R11 done after reset", done_o, 0);
      check(mem_rd_o == 0, "R11 read after reset", mem_rd_o, 0);
      check(frame_rdy_o == 0, "R11 frame_rdy after reset", frame_rdy_o, 0);
      check(byte_o == 0, "R11 byte after reset", byte_o, 0);
      tick(1);
      // R10: flag masked, then passed, then dropped
      frame_flag_i = 1'b1; tick(10);
      frame_en_i = 1'b1;   tick(10);
      frame_flag_i = 1'b0; tick(5);
      frame_flag_i = 1'b1; frame_en_i = 1'b0; tick(5);
      // transfer 1, request held high afterwards (R8)
      start_xfer();
      wait_done(1);
      tick(400);
      check(exp_q.size() == 0, "R8 no resend while request held", exp_q.size(), 0);
      // transfer 2: drop mid-way (R9), re-raise while busy (R12)
      req_i = 1'b0; tick(20);
      start_xfer();
      tick(200);
      req_i = 1'b0;
      tick(100);
      req_i = 1'b1;
      check(open_xfer == 1, "R9 transfer continues after request drop", open_xfer, 1);
      wait_done(2);
      tick(400);
      check(exp_q.size() == 0, "R12 re-raise during transfer ignored", exp_q.size(), 0);
      // transfer 3: short request pulse, enable toggling
      req_i = 1'b0; tick(10);
      start_xfer();
      tick(6);
      req_i = 1'b0;
      frame_flag_i = 1'b1; frame_en_i = 1'b1; tick(300);
      frame_en_i = 1'b0;
      wait_done(3);
      tick(50);
      check(exp_addr == 3 * MBW, "R2 address continues across transfers", exp_addr, 3 * MBW);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule